// File: doc/BRIEF.md
# Hashed MAC Forwarding Lookup Engine

For each received frame this block takes the destination MAC address and the ingress port number, and returns the set of egress ports as a port mask. An address table in on-chip RAM is split into hash buckets. The bucket is selected by folding the low 24 bits of the address (the device serial portion) into an 8-bit hash. The entries of the bucket are then scanned one per clock for a valid entry whose full 48-bit address matches.

The decision has three outcomes. A match on another port forwards the frame to that port only. A match on the ingress port discards the frame. A miss floods the frame to every port except the ingress port. Group addresses, which are broadcast and multicast, are not looked up and are always flooded the same way. A learning agent fills the table through a separate write port. The lookup side uses a valid/ready request and returns a one-cycle result pulse.

Top module: `mac_fwd_lookup`

## Requirements
- R1: After reset, req_ready is 1 and res_valid is 0.
- R2: The bucket of an address is mac[23:16] ^ mac[15:8] ^ mac[7:0]. Table entry {bucket, way} (address = bucket*8 + way) is searched only for addresses that hash to that bucket. An entry written in any other bucket is never found.
- R3: When a valid entry matches and its port differs from the ingress port, res_mask has only bit <entry port> set, with res_hit=1, res_discard=0 and res_flood=0 (mask bit n is port n).
- R4: When a valid entry matches and its port equals the ingress port, res_mask is 0, with res_hit=1, res_discard=1 and res_flood=0.
- R5: When no valid entry in the bucket matches, res_mask is all ones except the ingress bit, with res_flood=1, res_hit=0 and res_discard=0.
- R6: An address whose group bit mac[40] is 1 (broadcast or multicast) is flooded like R5, whatever the table holds. res_valid rises in the cycle right after the accepting edge.
- R7: When several valid entries in a bucket match, the one at the lowest way decides.
- R8: Entries written with the valid bit 0 never match.
- R9: A match requires all 48 address bits to be equal. Equal low 24 bits alone do not match.
- R10: For a unicast lookup accepted at edge E, a match at way w raises res_valid after edge E+w+2, and a miss raises it after edge E+9. res_valid lasts one cycle.
- R11: req_ready is 0 while a unicast scan is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Engine can accept a request |
| req_mac | input | 48 | Destination MAC address |
| req_port | input | 4 | Ingress port number |
| res_valid | output | 1 | Result valid, one-cycle pulse |
| res_mask | output | 16 | Egress port mask |
| res_hit | output | 1 | Address found in the table |
| res_discard | output | 1 | Frame dropped because the destination is on the ingress port |
| res_flood | output | 1 | Frame sent to all ports except the ingress port |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_addr | input | 11 | Table entry address, {bucket, way} |
| tbl_wr_mac | input | 48 | MAC address stored in the entry |
| tbl_wr_port | input | 4 | Port number stored in the entry |
| tbl_wr_valid | input | 1 | Valid bit stored in the entry |

## Verification
The assertions assume that the table is not written while a scan is in progress. Under that assumption the entry data compared in each cycle belongs to the bucket that was requested. They also assume that the ingress port held with a request is the one the result refers to. The stimulus writes every table entry before it issues the lookups that depend on it. It issues one request at a time and waits for the result before the next, so writes and scans never overlap.

// File: rtl/mfl_pkg.sv
// Shared types for the MAC forwarding lookup engine.
// Assumes nothing beyond IEEE 1800-2017 packages.
package mfl_pkg;
    // Controller state: idle and ready, or scanning a bucket.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } mfl_state_e;
endpackage

// File: rtl/mfl_hash.sv
// Folds a key into HASH_W bits by XOR of its HASH_W-wide chunks.
// Assumes KEY_W is a multiple of HASH_W.
module mfl_hash #(
    parameter int KEY_W  = 24,
    parameter int HASH_W = 8
) (
    input  logic [KEY_W-1:0]  key,
    output logic [HASH_W-1:0] hash
);
    localparam int CHUNKS = KEY_W / HASH_W;

    // XOR together every chunk of the key.
    always_comb begin
        hash = '0;
        for (int i = 0; i < CHUNKS; i++) begin
            hash = hash ^ key[i*HASH_W +: HASH_W];
        end
    end
endmodule

// File: rtl/mfl_table.sv
// Address table: one write port, one read port with a registered read.
// The valid bits are held in flops so that reset empties the table. The
// address and port fields are plain RAM.
// Assumes that a read and a write of the same entry in one cycle need not
// forward the new data.
module mfl_table #(
    parameter int MAC_W  = 48,
    parameter int PORT_W = 4,
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [MAC_W-1:0]  wr_mac,
    input  logic [PORT_W-1:0] wr_port,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [MAC_W-1:0]  rd_mac,
    output logic [PORT_W-1:0] rd_port,
    output logic              rd_valid
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [MAC_W-1:0]  mac_mem  [DEPTH];
    logic [PORT_W-1:0] port_mem [DEPTH];
    logic [DEPTH-1:0]  vld_q;

    // Write the address and port fields, then read them back registered.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mac_mem[wr_addr]  <= wr_mac;
            port_mem[wr_addr] <= wr_port;
        end
        rd_mac  <= mac_mem[rd_addr];
        rd_port <= port_mem[rd_addr];
    end

    // Valid bits: cleared by reset, set or cleared by a write, read registered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q    <= '0;
            rd_valid <= 1'b0;
        end else begin
            if (wr_en) vld_q[wr_addr] <= wr_valid;
            rd_valid <= vld_q[rd_addr];
        end
    end
endmodule

// File: rtl/mfl_ctrl.sv
// Lookup controller. It accepts a request and either floods group addresses
// at once or scans the bucket one way per cycle. The scan issues a read each
// cycle and compares the data of the previous read. It stops at the first
// valid full match or after the last way, and then builds the mask.
// Assumes the table is stable during a scan.
module mfl_ctrl
    import mfl_pkg::*;
#(
    parameter int NUM_PORTS = 16,
    parameter int PORT_W    = 4,
    parameter int MAC_W     = 48,
    parameter int HASH_W    = 8,
    parameter int WAYS      = 8,
    parameter int WAY_W     = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [MAC_W-1:0]        req_mac,
    input  logic [PORT_W-1:0]       req_port,
    input  logic [HASH_W-1:0]       req_hash,
    output logic [HASH_W+WAY_W-1:0] rd_addr,
    input  logic [MAC_W-1:0]        rd_mac,
    input  logic [PORT_W-1:0]       rd_port,
    input  logic                    rd_valid,
    output logic                    res_valid,
    output logic [NUM_PORTS-1:0]    res_mask,
    output logic                    res_hit,
    output logic                    res_discard,
    output logic                    res_flood
);
    localparam int IG_BIT = MAC_W - 8;
    localparam logic [WAY_W:0] WAYS_C = (WAY_W+1)'(WAYS);
    localparam logic [WAY_W:0] LAST_C = (WAY_W+1)'(WAYS - 1);

    mfl_state_e         state;
    logic [MAC_W-1:0]   key_mac;
    logic [PORT_W-1:0]  key_port;
    logic [HASH_W-1:0]  bucket;
    logic [WAY_W:0]     iss_cnt;
    logic               cmp_pend;
    logic               cmp_last;
    logic [NUM_PORTS-1:0] flood_mask;
    logic [NUM_PORTS-1:0] entry_mask;
    logic               accept;
    logic               match;
    logic [4:0]         lat_cnt;

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign rd_addr   = {bucket, iss_cnt[WAY_W-1:0]};
    assign match     = cmp_pend && rd_valid && (rd_mac == key_mac);

    // Masks: all ports but the ingress one, and the one-hot entry port.
    always_comb begin
        flood_mask = '0;
        entry_mask = '0;
        for (int i = 0; i < NUM_PORTS; i++) begin
            flood_mask[i] = (PORT_W'(i) != key_port);
            entry_mask[i] = (PORT_W'(i) == rd_port);
        end
    end

    // Request capture, scan sequencing and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            key_mac     <= '0;
            key_port    <= '0;
            bucket      <= '0;
            iss_cnt     <= '0;
            cmp_pend    <= 1'b0;
            cmp_last    <= 1'b0;
            res_valid   <= 1'b0;
            res_mask    <= '0;
            res_hit     <= 1'b0;
            res_discard <= 1'b0;
            res_flood   <= 1'b0;
        end else begin
            res_valid <= 1'b0;
            if (state == ST_IDLE) begin
                cmp_pend <= 1'b0;
                if (accept) begin
                    key_mac  <= req_mac;
                    key_port <= req_port;
                    bucket   <= req_hash;
                    iss_cnt  <= '0;
                    if (req_mac[IG_BIT]) begin
                        res_valid   <= 1'b1;
                        res_hit     <= 1'b0;
                        res_discard <= 1'b0;
                        res_flood   <= 1'b1;
                        res_mask    <= '0;
                        for (int i = 0; i < NUM_PORTS; i++)
                            res_mask[i] <= (PORT_W'(i) != req_port);
                    end else begin
                        state <= ST_SCAN;
                    end
                end
            end else begin
                cmp_pend <= (iss_cnt < WAYS_C);
                cmp_last <= (iss_cnt == LAST_C);
                if (iss_cnt < WAYS_C) iss_cnt <= iss_cnt + 1'b1;
                if (match) begin
                    state       <= ST_IDLE;
                    cmp_pend    <= 1'b0;
                    res_valid   <= 1'b1;
                    res_hit     <= 1'b1;
                    res_flood   <= 1'b0;
                    res_discard <= (rd_port == key_port);
                    res_mask    <= (rd_port == key_port) ? '0 : entry_mask;
                end else if (cmp_pend && cmp_last) begin
                    state       <= ST_IDLE;
                    cmp_pend    <= 1'b0;
                    res_valid   <= 1'b1;
                    res_hit     <= 1'b0;
                    res_discard <= 1'b0;
                    res_flood   <= 1'b1;
                    res_mask    <= flood_mask;
                end
            end
        end
    end

    // Cycles spent in the scan state, used only by the bound check below.
    always_ff @(posedge clk) begin
        if (!rst_n || state == ST_IDLE) lat_cnt <= '0;
        else if (lat_cnt != '1)         lat_cnt <= lat_cnt + 1'b1;
    end

    // R3
    fwd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_hit && !res_discard) |->
            ($countones(res_mask) == 1 && !res_mask[key_port] && !res_flood));

    // R4
    discard_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_discard) |-> (res_mask == '0 && res_hit && !res_flood));

    // R5
    flood_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_flood) |->
            (!res_mask[key_port] && $countones(res_mask) == NUM_PORTS - 1 && !res_hit));

    // R6
    group_flood_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && key_mac[IG_BIT]) |-> (res_flood && !res_hit));

    // R10
    scan_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SCAN) |-> (lat_cnt <= 5'(WAYS + 1)));

    // R10
    pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R11
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !req_mac[IG_BIT]) |=> !req_ready);
endmodule

// File: rtl/mac_fwd_lookup.sv
// Top of the hashed MAC forwarding lookup engine: bucket hash, address
// table and scan controller.
// Assumes that table writes come only between lookups.
module mac_fwd_lookup #(
    parameter int NUM_PORTS = 16,
    parameter int MAC_W     = 48,
    parameter int SERIAL_W  = 24,
    parameter int HASH_W    = 8,
    parameter int WAYS      = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic [MAC_W-1:0]            req_mac,
    input  logic [$clog2(NUM_PORTS)-1:0] req_port,
    output logic                        res_valid,
    output logic [NUM_PORTS-1:0]        res_mask,
    output logic                        res_hit,
    output logic                        res_discard,
    output logic                        res_flood,
    input  logic                        tbl_wr_en,
    input  logic [HASH_W+$clog2(WAYS)-1:0] tbl_wr_addr,
    input  logic [MAC_W-1:0]            tbl_wr_mac,
    input  logic [$clog2(NUM_PORTS)-1:0] tbl_wr_port,
    input  logic                        tbl_wr_valid
);
    localparam int PORT_W = $clog2(NUM_PORTS);
    localparam int WAY_W  = $clog2(WAYS);
    localparam int ADDR_W = HASH_W + WAY_W;

    logic [HASH_W-1:0] req_hash;
    logic [ADDR_W-1:0] rd_addr;
    logic [MAC_W-1:0]  rd_mac;
    logic [PORT_W-1:0] rd_port;
    logic              rd_valid;

    mfl_hash #(.KEY_W(SERIAL_W), .HASH_W(HASH_W)) u_hash (
        .key  (req_mac[SERIAL_W-1:0]),
        .hash (req_hash)
    );

    mfl_table #(.MAC_W(MAC_W), .PORT_W(PORT_W), .ADDR_W(ADDR_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_wr_en),
        .wr_addr  (tbl_wr_addr),
        .wr_mac   (tbl_wr_mac),
        .wr_port  (tbl_wr_port),
        .wr_valid (tbl_wr_valid),
        .rd_addr  (rd_addr),
        .rd_mac   (rd_mac),
        .rd_port  (rd_port),
        .rd_valid (rd_valid)
    );

    mfl_ctrl #(
        .NUM_PORTS (NUM_PORTS),
        .PORT_W    (PORT_W),
        .MAC_W     (MAC_W),
        .HASH_W    (HASH_W),
        .WAYS      (WAYS),
        .WAY_W     (WAY_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_mac     (req_mac),
        .req_port    (req_port),
        .req_hash    (req_hash),
        .rd_addr     (rd_addr),
        .rd_mac      (rd_mac),
        .rd_port     (rd_port),
        .rd_valid    (rd_valid),
        .res_valid   (res_valid),
        .res_mask    (res_mask),
        .res_hit     (res_hit),
        .res_discard (res_discard),
        .res_flood   (res_flood)
    );
endmodule

// File: tb/test_mac_fwd_lookup.sv
// Directed bench for mac_fwd_lookup. Each scenario task drives its stimulus
// and checks its own results, sampling at the falling edge.
module test_mac_fwd_lookup;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [47:0] req_mac = '0;
    logic [3:0]  req_port = '0;
    logic        res_valid;
    logic [15:0] res_mask;
    logic        res_hit, res_discard, res_flood;
    logic        tbl_wr_en = 1'b0;
    logic [10:0] tbl_wr_addr = '0;
    logic [47:0] tbl_wr_mac = '0;
    logic [3:0]  tbl_wr_port = '0;
    logic        tbl_wr_valid = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    mac_fwd_lookup i_mac_fwd_lookup (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_mac(req_mac), .req_port(req_port),
        .res_valid(res_valid), .res_mask(res_mask), .res_hit(res_hit),
        .res_discard(res_discard), .res_flood(res_flood),
        .tbl_wr_en(tbl_wr_en), .tbl_wr_addr(tbl_wr_addr), .tbl_wr_mac(tbl_wr_mac),
        .tbl_wr_port(tbl_wr_port), .tbl_wr_valid(tbl_wr_valid)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] bkt(input logic [47:0] m);
        return m[23:16] ^ m[15:8] ^ m[7:0];
    endfunction

    task automatic wr(input logic [7:0] b, input int way, input logic [47:0] m,
                      input logic [3:0] p, input logic v);
        @(negedge clk);
        tbl_wr_en = 1'b1; tbl_wr_addr = {b, 3'(way)};
        tbl_wr_mac = m; tbl_wr_port = p; tbl_wr_valid = v;
        @(negedge clk);
        tbl_wr_en = 1'b0;
    endtask

    function automatic logic [15:0] flood(input logic [3:0] p);
        return 16'hFFFF & ~(16'h1 << p);
    endfunction

    // One lookup; checks mask, flags, latency in falling edges after accept.
    task automatic lookup(input string tag, input logic [47:0] m, input logic [3:0] p,
                          input logic [15:0] em, input logic eh, input logic ed,
                          input logic ef, input int elat);
        int n;
        @(negedge clk);
        req_valid = 1'b1; req_mac = m; req_port = p;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (!m[40]) chk({tag, " R11 ready low while scanning"}, 32'(req_ready), 32'd0);
        n = 0;
        while (!res_valid && n < 40) begin
            @(negedge clk);
            n++;
        end
        chk({tag, " mask"}, 32'(res_mask), 32'(em));
        chk({tag, " hit"}, 32'(res_hit), 32'(eh));
        chk({tag, " discard"}, 32'(res_discard), 32'(ed));
        chk({tag, " flood"}, 32'(res_flood), 32'(ef));
        chk({tag, " R10 latency"}, 32'(n), 32'(elat));
        @(negedge clk);
        chk({tag, " R10 single pulse"}, 32'(res_valid), 32'd0);
    endtask

    localparam logic [47:0] MAC_A = 48'h02AA_BB12_3456;
    localparam logic [47:0] MAC_B = 48'h0411_2233_4455;
    localparam logic [47:0] MAC_M = 48'h0100_5E01_0203;
    localparam logic [47:0] MAC_C = 48'h0A00_0000_0F0F;
    localparam logic [47:0] MAC_D = 48'h0C00_0010_0000;
    localparam logic [47:0] MAC_E = 48'h0200_0012_3456;
    localparam logic [47:0] MAC_F = 48'h0600_0000_0055;

    task automatic t_reset();
        chk("R1 ready after reset", 32'(req_ready), 32'd1);
        chk("R1 no result after reset", 32'(res_valid), 32'd0);
    endtask

    task automatic t_forward();
        wr(bkt(MAC_A), 3, MAC_A, 4'd5, 1'b1);
        lookup("R3 forward", MAC_A, 4'd2, 16'h0020, 1'b1, 1'b0, 1'b0, 5);
    endtask

    task automatic t_discard();
        lookup("R4 same port", MAC_A, 4'd5, 16'h0000, 1'b1, 1'b1, 1'b0, 5);
    endtask

    task automatic t_unknown();
        lookup("R5 unknown", MAC_B, 4'd7, flood(4'd7), 1'b0, 1'b0, 1'b1, 9);
    endtask

    task automatic t_group();
        wr(bkt(MAC_M), 0, MAC_M, 4'd9, 1'b1);
        lookup("R6 multicast", MAC_M, 4'd3, flood(4'd3), 1'b0, 1'b0, 1'b1, 0);
        lookup("R6 broadcast", 48'hFFFF_FFFF_FFFF, 4'd0, 16'hFFFE, 1'b0, 1'b0, 1'b1, 0);
    endtask

    task automatic t_first_match();
        wr(bkt(MAC_C), 5, MAC_C, 4'd6, 1'b1);
        wr(bkt(MAC_C), 2, MAC_C, 4'd1, 1'b1);
        lookup("R7 lowest way wins", MAC_C, 4'd12, 16'h0002, 1'b1, 1'b0, 1'b0, 4);
    endtask

    task automatic t_invalid_skip();
        wr(bkt(MAC_D), 0, MAC_D, 4'd4, 1'b0);
        wr(bkt(MAC_D), 6, MAC_D, 4'd8, 1'b1);
        lookup("R8 invalid skipped", MAC_D, 4'd0, 16'h0100, 1'b1, 1'b0, 1'b0, 8);
    endtask

    task automatic t_full_compare();
        lookup("R9 upper bits differ", MAC_E, 4'd1, flood(4'd1), 1'b0, 1'b0, 1'b1, 9);
    endtask

    task automatic t_bucket();
        wr(bkt(MAC_F) ^ 8'h01, 0, MAC_F, 4'd3, 1'b1);
        lookup("R2 wrong bucket", MAC_F, 4'd10, flood(4'd10), 1'b0, 1'b0, 1'b1, 9);
        wr(bkt(MAC_F), 7, MAC_F, 4'd2, 1'b1);
        lookup("R2 right bucket last way", MAC_F, 4'd10, 16'h0004, 1'b1, 1'b0, 1'b0, 9);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_forward();
        t_discard();
        t_unknown();
        t_group();
        t_first_match();
        t_invalid_skip();
        t_full_compare();
        t_bucket();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule